// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts the next fetch address for an instruction fetch stage. It holds a small direct-mapped table with one entry per indexed slot. Each entry keeps a valid bit, an address tag, the branch target computed the last time the branch ran, and a 2-bit saturating counter that supplies hysteresis for the taken/not-taken decision. In the fetch cycle the table is read combinationally. If the entry hits and its counter leans toward taken, the stored target becomes the next PC. In every other case the next PC is the fetch address plus 4.

A resolution port is driven by the pipeline stage that resolves branches. It carries the branch address, the actual outcome, the computed target and the prediction that fetch made for that branch. The block writes a new entry the first time a branch resolves. On later resolutions it moves the counter and refreshes the target. It also raises a combinational mispredict flag together with the correct redirect address, so the pipeline can flush the wrong-path instructions.

With the default parameters the table has 16 entries. The index is PC bits [5:2] and the tag is PC bits [31:6].

Top module: `btb_predictor`

## Requirements
- R1: A synchronous active-high reset invalidates every entry, so after reset every lookup predicts not taken with next PC equal to fetch_pc + 4.
- R2: When the fetch address misses, either because the slot is invalid or because the tag differs, pred_taken is 0 and pred_next_pc is fetch_pc + 4.
- R3: A branch that resolves taken and misses in the table is allocated with counter value 2 and the resolved target. A later fetch of that address predicts taken and returns that target.
- R4: A branch that resolves not taken and misses in the table is allocated with counter value 1, so it predicts not taken. One taken resolution afterwards moves it to 2, which predicts taken.
- R5: On a hit the counter increments on a taken resolution and decrements on a not-taken one. It saturates at 3 and at 0. Values 2 and 3 predict taken; values 0 and 1 predict not taken.
- R6: Two addresses with the same PC[5:2] but different upper bits do not share a prediction. Resolving the second one replaces the first one's entry.
- R7: When res_valid is high, mispredict is raised if res_taken differs from res_pred_taken. mispredict is 0 while res_valid is low, and an invalid resolution leaves the table unchanged.
- R8: mispredict is also raised on a taken resolution that was predicted taken but whose res_pred_target differs from res_target.
- R9: redirect_pc equals res_target when res_taken is 1 and res_pc + 4 otherwise.
- R10: A lookup and an update to the same entry in the same cycle return the contents from before the update. The update becomes visible in the next cycle.
- R11: A taken resolution that hits replaces the stored target with res_target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Fetch address predicted as a taken branch |
| res_valid | input | 1 | A branch resolution is presented this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual branch outcome |
| res_target | input | 32 | Computed branch target |
| res_pred_taken | input | 1 | Direction predicted for this branch at fetch |
| res_pred_target | input | 32 | Target predicted for this branch at fetch |
| mispredict | output | 1 | Prediction was wrong; the pipeline must flush |
| redirect_pc | output | 32 | Correct address to resume fetch from |

## Verification
A fetch lookup and a resolution write can hit the same table slot in the same clock cycle. The bench provokes this by presenting a resolution for address A while fetch_pc is also A. It checks that the prediction in that cycle still reflects the old counter and target, and that the next cycle shows the updated entry. The counter sequences are chosen so that a wrap at either end would flip the pre-update prediction, so the same overlapping cycles also expose saturation faults.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_T    = 2'd2,
        CTR_STRONG_T  = 2'd3
    } ctr_t;

    // Counter value given to a freshly allocated entry
    function automatic ctr_t ctr_alloc(input logic taken);
        return taken ? CTR_WEAK_T : CTR_WEAK_NT;
    endfunction

    // Saturating step toward the observed outcome
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != CTR_STRONG_T)
            nxt = ctr_t'(cur + 2'd1);
        else if (!taken && cur != CTR_STRONG_NT)
            nxt = ctr_t'(cur - 2'd1);
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W   = ADDR_W - IDX_W - 2,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    // fetch read port
    input  logic [IDX_W-1:0]  f_idx,
    output logic              f_valid,
    output logic [TAG_W-1:0]  f_tag,
    output logic [ADDR_W-1:0] f_target,
    output ctr_t              f_ctr,
    // resolution read port
    input  logic [IDX_W-1:0]  u_idx,
    output logic              u_valid,
    output logic [TAG_W-1:0]  u_tag,
    output ctr_t              u_ctr,
    // write port
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target,
    input  ctr_t              wr_ctr
);

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  target_q [ENTRIES];
    ctr_t               ctr_q    [ENTRIES];

    genvar gi;
    generate
        for (gi = 0; gi < ENTRIES; gi++) begin : g_slot
            logic hit_wr;
            assign hit_wr = wr_en && (wr_idx == IDX_W'(gi));

            always_ff @(posedge clk) begin
                if (rst)
                    valid_q[gi] <= 1'b0;
                else if (hit_wr)
                    valid_q[gi] <= 1'b1;
            end

            always_ff @(posedge clk) begin
                if (hit_wr) begin
                    tag_q[gi]    <= wr_tag;
                    target_q[gi] <= wr_target;
                    ctr_q[gi]    <= wr_ctr;
                end
            end
        end
    endgenerate

    // Reads come from registers, so a same-cycle write is seen one cycle later
    always_comb begin
        f_valid  = valid_q[f_idx];
        f_tag    = tag_q[f_idx];
        f_target = target_q[f_idx];
        f_ctr    = ctr_q[f_idx];
        u_valid  = valid_q[u_idx];
        u_tag    = tag_q[u_idx];
        u_ctr    = ctr_q[u_idx];
    end

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              e_valid,
    input  logic [TAG_W-1:0]  e_tag,
    input  logic [ADDR_W-1:0] e_target,
    input  ctr_t              e_ctr,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic hit;

    always_comb begin
        hit          = e_valid && (e_tag == fetch_pc[ADDR_W-1 -: TAG_W]);
        pred_taken   = hit && ctr_says_taken(e_ctr);
        pred_next_pc = pred_taken ? e_target : fetch_pc + STEP;
    end

endmodule

// File: rtl/btb_update.sv
module btb_update
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - IDX_W - 2
) (
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    input  logic              e_valid,
    input  logic [TAG_W-1:0]  e_tag,
    input  ctr_t              e_ctr,
    input  logic [ADDR_W-1:0] e_target,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [ADDR_W-1:0] wr_target,
    output ctr_t              wr_ctr,
    output logic              mispredict,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic hit;
    logic dir_wrong;
    logic tgt_wrong;

    always_comb begin
        hit    = e_valid && (e_tag == res_pc[ADDR_W-1 -: TAG_W]);
        wr_en  = res_valid;
        wr_tag = res_pc[ADDR_W-1 -: TAG_W];
        if (hit) begin
            wr_ctr    = ctr_step(e_ctr, res_taken);
            wr_target = res_taken ? res_target : e_target;
        end else begin
            wr_ctr    = ctr_alloc(res_taken);
            wr_target = res_target;
        end

        dir_wrong   = res_taken != res_pred_taken;
        tgt_wrong   = res_taken && res_pred_taken && (res_pred_target != res_target);
        mispredict  = res_valid && (dir_wrong || tgt_wrong);
        redirect_pc = res_taken ? res_target : res_pc + STEP;
    end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic [ADDR_W-1:0] pred_next_pc,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              mispredict,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam int TAG_W = ADDR_W - IDX_W - 2;

    logic              f_valid;
    logic [TAG_W-1:0]  f_tag;
    logic [ADDR_W-1:0] f_target;
    ctr_t              f_ctr;
    logic              u_valid;
    logic [TAG_W-1:0]  u_tag;
    ctr_t              u_ctr;
    logic [ADDR_W-1:0] u_target;
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [ADDR_W-1:0] wr_target;
    ctr_t              wr_ctr;

    logic [IDX_W-1:0] f_idx;
    logic [IDX_W-1:0] u_idx;
    assign f_idx = fetch_pc[IDX_W+1:2];
    assign u_idx = res_pc[IDX_W+1:2];

    // Target of the slot being updated, needed to keep it on a not-taken hit
    btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_tgt_view (
        .clk(clk), .rst(rst),
        .f_idx(u_idx), .f_valid(), .f_tag(), .f_target(u_target), .f_ctr(),
        .u_idx(u_idx), .u_valid(), .u_tag(), .u_ctr(),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst(rst),
        .f_idx(f_idx), .f_valid(f_valid), .f_tag(f_tag),
        .f_target(f_target), .f_ctr(f_ctr),
        .u_idx(u_idx), .u_valid(u_valid), .u_tag(u_tag), .u_ctr(u_ctr),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(wr_tag),
        .wr_target(wr_target), .wr_ctr(wr_ctr)
    );

    btb_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lookup (
        .fetch_pc(fetch_pc),
        .e_valid(f_valid), .e_tag(f_tag), .e_target(f_target), .e_ctr(f_ctr),
        .pred_taken(pred_taken), .pred_next_pc(pred_next_pc)
    );

    btb_update #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_update (
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_pred_taken(res_pred_taken),
        .res_pred_target(res_pred_target),
        .e_valid(u_valid), .e_tag(u_tag), .e_ctr(u_ctr), .e_target(u_target),
        .wr_en(wr_en), .wr_tag(wr_tag), .wr_target(wr_target), .wr_ctr(wr_ctr),
        .mispredict(mispredict), .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic [ADDR_W-1:0] pred_next_pc,
    input logic              pred_taken,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              res_pred_taken,
    input logic [ADDR_W-1:0] res_pred_target,
    input logic              mispredict,
    input logic [ADDR_W-1:0] redirect_pc
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pred_taken);

    p_seq_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        !pred_taken |-> pred_next_pc == fetch_pc + STEP);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !mispredict);

    p_dir_wrong_r7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken != res_pred_taken) |-> mispredict);

    p_tgt_wrong_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_taken && res_pred_taken && res_pred_target != res_target)
        |-> mispredict);

    p_redirect_nt_r9: assert property (@(posedge clk) disable iff (rst)
        (mispredict && !res_taken) |-> redirect_pc == res_pc + STEP);

endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
    .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target),
    .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;

    typedef struct packed {
        logic          rv;
        logic [AW-1:0] rpc;
        logic          rtk;
        logic [AW-1:0] rtgt;
        logic          rptk;
        logic [AW-1:0] rptgt;
        logic [AW-1:0] fpc;
        logic          e_ptk;
        logic [AW-1:0] e_next;
        logic          e_mp;
        logic [AW-1:0] e_rd;
    } vec_t;

    localparam logic [AW-1:0] PA = 32'h0000_1044;  // index 1
    localparam logic [AW-1:0] PB = 32'h0000_2044;  // index 1, other tag
    localparam logic [AW-1:0] PC = 32'h0000_0108;  // index 2
    localparam logic [AW-1:0] Z  = 32'h0;
    localparam int NV = 20;

    localparam vec_t VECS [NV] = '{
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PA, 1'b0, 32'h1048, 1'b0, 32'h4},     // 0 R1/R2
        '{1'b1, PA, 1'b1, 32'h3000,     1'b0, Z,            PA, 1'b0, 32'h1048, 1'b1, 32'h3000},  // 1 R10 R7
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PA, 1'b1, 32'h3000, 1'b0, 32'h4},     // 2 R3
        '{1'b1, PA, 1'b1, 32'h3000,     1'b1, 32'h3000,     PA, 1'b1, 32'h3000, 1'b0, 32'h3000},  // 3
        '{1'b1, PA, 1'b1, 32'h3000,     1'b1, 32'h3000,     PA, 1'b1, 32'h3000, 1'b0, 32'h3000},  // 4 sat 3
        '{1'b1, PA, 1'b0, 32'h3000,     1'b1, 32'h3000,     PA, 1'b1, 32'h3000, 1'b1, 32'h1048},  // 5 R5 R9
        '{1'b1, PA, 1'b0, 32'h3000,     1'b1, 32'h3000,     PA, 1'b1, 32'h3000, 1'b1, 32'h1048},  // 6
        '{1'b1, PA, 1'b0, 32'h3000,     1'b0, Z,            PA, 1'b0, 32'h1048, 1'b0, 32'h1048},  // 7
        '{1'b1, PA, 1'b0, 32'h3000,     1'b0, Z,            PA, 1'b0, 32'h1048, 1'b0, 32'h1048},  // 8 sat 0
        '{1'b1, PA, 1'b1, 32'h3400,     1'b0, Z,            PA, 1'b0, 32'h1048, 1'b1, 32'h3400},  // 9
        '{1'b1, PA, 1'b1, 32'h3400,     1'b0, Z,            PA, 1'b0, 32'h1048, 1'b1, 32'h3400},  // 10
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PA, 1'b1, 32'h3400, 1'b0, 32'h4},     // 11 R11
        '{1'b1, PB, 1'b0, 32'h5000,     1'b0, Z,            PB, 1'b0, 32'h2048, 1'b0, 32'h2048},  // 12 R6
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PA, 1'b0, 32'h1048, 1'b0, 32'h4},     // 13 R6 evicted
        '{1'b1, PB, 1'b1, 32'h5000,     1'b0, Z,            PB, 1'b0, 32'h2048, 1'b1, 32'h5000},  // 14 R4
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PB, 1'b1, 32'h5000, 1'b0, 32'h4},     // 15 R4
        '{1'b1, PB, 1'b1, 32'h5100,     1'b1, 32'h5000,     PC, 1'b0, 32'h010C, 1'b1, 32'h5100},  // 16 R8
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PB, 1'b1, 32'h5100, 1'b0, 32'h4},     // 17 R11
        '{1'b0, PB, 1'b1, 32'h7000,     1'b0, Z,            PB, 1'b1, 32'h5100, 1'b0, 32'h7000},  // 18 R7 idle
        '{1'b0, Z,  1'b0, Z,            1'b0, Z,            PB, 1'b1, 32'h5100, 1'b0, 32'h4}      // 19 R7 unchanged
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] fetch_pc;
    logic [AW-1:0] pred_next_pc;
    logic          pred_taken;
    logic          res_valid;
    logic [AW-1:0] res_pc;
    logic          res_taken;
    logic [AW-1:0] res_target;
    logic          res_pred_taken;
    logic [AW-1:0] res_pred_target;
    logic          mispredict;
    logic [AW-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    btb_predictor u_btb_predictor (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_next_pc(pred_next_pc),
        .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
        .mispredict(mispredict), .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle(input logic [AW-1:0] pc);
        res_valid = 1'b0; res_pc = Z; res_taken = 1'b0; res_target = Z;
        res_pred_taken = 1'b0; res_pred_target = Z; fetch_pc = pc;
    endtask

    initial begin
        rst = 1'b1;
        drive_idle(PA);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Vector walk: outputs are sampled before the edge that commits the update
        for (int i = 0; i < NV; i++) begin
            res_valid       = VECS[i].rv;
            res_pc          = VECS[i].rpc;
            res_taken       = VECS[i].rtk;
            res_target      = VECS[i].rtgt;
            res_pred_taken  = VECS[i].rptk;
            res_pred_target = VECS[i].rptgt;
            fetch_pc        = VECS[i].fpc;
            #1;
            check($sformatf("R2/R3/R5/R10 v%0d", i), "pred_taken",
                  AW'(pred_taken), AW'(VECS[i].e_ptk));
            check($sformatf("R3/R11 v%0d", i), "pred_next_pc",
                  pred_next_pc, VECS[i].e_next);
            check($sformatf("R7/R8 v%0d", i), "mispredict",
                  AW'(mispredict), AW'(VECS[i].e_mp));
            check($sformatf("R9 v%0d", i), "redirect_pc",
                  redirect_pc, VECS[i].e_rd);
            @(negedge clk);
        end

        // R1: reset in the middle of a run empties the table
        rst = 1'b1;
        drive_idle(PB);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "pred_taken after reset", AW'(pred_taken), AW'(1'b0));
        check("R1", "next pc after reset", pred_next_pc, 32'h2048);

        // R5: saturation at 3 on a fresh entry, then two not-taken needed
        @(negedge clk);
        res_valid = 1'b1; res_pc = PC; res_taken = 1'b1; res_target = 32'h0800;
        res_pred_taken = 1'b0; res_pred_target = Z; fetch_pc = PC;
        repeat (4) @(negedge clk);
        res_taken = 1'b0; res_pred_taken = 1'b1; res_pred_target = 32'h0800;
        @(negedge clk);
        drive_idle(PC);
        #1;
        check("R5", "taken after one NT from saturated", AW'(pred_taken), AW'(1'b1));
        check("R5", "target after one NT", pred_next_pc, 32'h0800);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule